// File: doc/BRIEF.md
# Slave-Mode Synchronous Serial Receiver

The block receives bytes from an external master that drives both a serial clock and a serial data line. The two lines are brought into the system clock domain through a chain of synchronizer flops. On every rising edge of the serial clock the block shifts in one data bit, most significant bit first. After the eighth bit it places the byte in a receive data register and sets a receive-full flag. Software reads the byte through a small register port, and that read clears the flag.

On the eighth rising edge of each frame the block checks whether the previous byte is still unread. If it is, the block raises an overrun flag, keeps the old byte and drops the new one. It then ignores all further serial traffic until software clears the overrun.

A status register also holds a transmit-end flag, which a neighbouring transmit engine sets. Software clears a status flag in two steps: it first reads the flag as 1, then writes 0 to it. Software may turn the receive enable on only while all three status flags are clear.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1) and the data register (address 2) all read 0. Address 3 reads 0.
- R2: With the enable set (control bit 0), eight rising serial clock edges assemble one byte, with the first bit received placed in bit 7. The byte appears in the data register and status bit 0 (receive-full) becomes 1.
- R3: If receive-full is 1 at the eighth rising edge of a frame, status bit 1 (overrun) becomes 1, the data register keeps its old byte, and the new byte is lost.
- R4: While overrun is 1, no frame is accepted: the data register and receive-full stay unchanged whatever the serial lines do.
- R5: A status flag is cleared only by writing 0 to its bit after a status read that returned that bit as 1. A write of 0 with no such prior read has no effect, and writing 1 never changes a flag.
- R6: Once overrun is cleared, reception resumes, and the next eight rising edges form a new byte.
- R7: A read of the data register clears receive-full.
- R8: A write of 1 to the enable bit is ignored while any status flag is 1, and the bit then reads back 0. Writing 0 always clears the bit.
- R9: While the enable is 0 the bit counter is held at 0. A partly received frame is discarded when the enable drops.
- R10: A pulse on `tx_end_set` sets status bit 2 (transmit-end). That flag clears through the R5 sequence.
- R11: Serial clock edges that arrive while the enable is 0 capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the external master (asynchronous) |
| sdata_in | input | 1 | Serial data, sampled on the serial clock rising edge (asynchronous) |
| tx_end_set | input | 1 | One-cycle pulse from the transmit engine that sets the transmit-end flag |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read has side effects on the status and data registers |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for the selected address (combinational) |

## Verification
The path from a serial clock rise at the pin to the register flags is four system clocks long: two synchronizer stages, the edge register, then the flag update. Each serial bit is therefore held for four clocks high and four clocks low, and each frame result is read only after the eighth bit period has fully elapsed. Register writes and read side effects take effect at the next clock edge. The bench drives the strobes for one cycle from a falling edge, samples read data one nanosecond later, and follows every write with a read in a later cycle. Every one of the 256 byte values is received, and each is checked for bit order and for the full/clear behaviour of the flag.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // packed order puts rx_full at bit 0, overrun at bit 1, tx_end at bit 2
    typedef struct packed {
        logic tx_end;
        logic overrun;
        logic rx_full;
    } flags_t;

    localparam int unsigned FLAG_W = $bits(flags_t);

    function automatic flags_t flags_from_bits(logic [FLAG_W-1:0] b);
        return flags_t'(b);
    endfunction

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= '0;
            else     stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
    parameter int unsigned FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  sclk_s,
    input  logic                  sdat_s,
    output logic                  done,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int unsigned CNT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic                  sclk_d;
    logic                  rise;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [FRAME_BITS-1:0] shreg_n;

    assign rise    = sclk_s & ~sclk_d;
    assign shreg_n = {shreg_q[FRAME_BITS-2:0], sdat_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            sclk_d <= sclk_s;
            done   <= 1'b0;
            if (!run) begin
                cnt_q <= '0;
            end else if (rise) begin
                shreg_q <= shreg_n;
                if (cnt_q == LAST_BIT) begin
                    cnt_q <= '0;
                    done  <= 1'b1;
                    frame <= shreg_n;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(run)) else $error("frame completed while halted"); // R4

    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !done) else $error("frame out of idle state"); // R9
endmodule

// File: rtl/ssrx_regs.sv
module ssrx_regs
    import ssrx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 8,
    parameter int unsigned REG_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_addr_e             addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic                  frame_done,
    input  logic [FRAME_BITS-1:0] frame_byte,
    input  logic                  tx_end_set,
    output logic                  run
);
    flags_t                flg_q, arm_q;
    logic                  en_q;
    logic [FRAME_BITS-1:0] dat_q;

    logic wr_ctrl, wr_stat, rd_stat, rd_data;
    logic [FLAG_W-1:0] cur, clr, setm, nxt, arm_n;
    logic wdata_unused;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_stat = wr_en && (addr == ADDR_STAT);
    assign rd_stat = rd_en && (addr == ADDR_STAT);
    assign rd_data = rd_en && (addr == ADDR_DATA);
    assign wdata_unused = ^wdata[REG_W-1:FLAG_W];

    always_comb begin
        cur  = flg_q;
        clr  = '0;
        setm = '0;
        if (wr_stat) clr = arm_q & ~wdata[FLAG_W-1:0];
        if (rd_data) clr[0] = 1'b1;
        setm[2] = tx_end_set;
        if (frame_done) begin
            if (flg_q.rx_full) setm[1] = 1'b1;
            else               setm[0] = 1'b1;
        end
        nxt   = (cur & ~clr) | setm;
        arm_n = ((rd_stat ? (arm_q | cur) : arm_q) & ~clr) & nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            arm_q <= '0;
            en_q  <= 1'b0;
            dat_q <= '0;
        end else begin
            flg_q <= flags_from_bits(nxt);
            arm_q <= flags_from_bits(arm_n);
            if (wr_ctrl) begin
                if (!wdata[0])   en_q <= 1'b0;
                else if (cur == '0) en_q <= 1'b1;
            end
            if (frame_done && !flg_q.rx_full) dat_q <= frame_byte;
        end
    end

    assign run = en_q & ~flg_q.overrun;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata[0] = en_q;
            ADDR_STAT: rdata[FLAG_W-1:0] = flg_q;
            ADDR_DATA: rdata[FRAME_BITS-1:0] = dat_q;
            default:   rdata = '0;
        endcase
    end

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (frame_done && flg_q.rx_full) |=> flg_q.overrun) else $error("overrun missed"); // R3

    AST_KEEP_OLD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (frame_done && flg_q.rx_full) |=> $stable(dat_q)) else $error("byte overwritten"); // R3

    AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> ($past(flg_q) == '0)) else $error("enable with flag set"); // R8

    AST_OVR_CLEAR_SEQ: assert property (@(posedge clk) disable iff (rst)
        $fell(flg_q.overrun) |-> $past(wr_stat && !wdata[1] && arm_q.overrun))
        else $error("overrun cleared without read-write sequence"); // R5
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssrx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 8,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             sdata_in,
    input  logic             tx_end_set,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    logic [1:0]            line_s;
    logic                  run;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_byte;

    ssrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({sclk_in, sdata_in}),
        .sync_out (line_s)
    );

    ssrx_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sclk_s (line_s[1]),
        .sdat_s (line_s[0]),
        .done   (frame_done),
        .frame  (frame_byte)
    );

    ssrx_regs #(.FRAME_BITS(FRAME_BITS), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (reg_addr_e'(reg_addr)),
        .wr_en      (reg_wr),
        .rd_en      (reg_rd),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .frame_done (frame_done),
        .frame_byte (frame_byte),
        .tx_end_set (tx_end_set),
        .run        (run)
    );
endmodule

// File: tb/tb_sync_serial_rx.sv
`timescale 1ns/1ps
module tb_sync_serial_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0, sdata_in = 1'b0, tx_end_set = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sync_serial_rx dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk);
            sdata_in = v[i];
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 stat", d, 0);
        rd(2'd2, d); chk("R1 data", d, 0);
        rd(2'd3, d); chk("R1 unused addr", d, 0);

        // R11: traffic while disabled is not captured
        send_bits(8'hC3, 8);
        rd(2'd1, d); chk("R11 stat idle", d, 0);
        rd(2'd2, d); chk("R11 data idle", d, 0);

        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R8 enable accepted", d, 1);

        // R2/R7 sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            send_bits(8'(v), 8);
            rd(2'd1, d); chk("R2 full set", d, 1);
            rd(2'd2, d); chk("R2 byte msb first", d, v);
            rd(2'd1, d); chk("R7 full cleared by data read", d, 0);
        end

        // R3 overrun
        send_bits(8'hA5, 8);
        send_bits(8'h3C, 8);
        wr(2'd1, 8'h00);                 // unarmed write: no effect (R5)
        rd(2'd2, d); chk("R3 old byte kept", d, 8'hA5);
        send_bits(8'hFF, 8);
        rd(2'd1, d); chk("R4 halted, overrun kept (R5 unarmed)", d, 2);
        rd(2'd2, d); chk("R4 data unchanged", d, 8'hA5);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); chk("R5 write 1 no effect", d, 2);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R5 armed clear", d, 0);
        send_bits(8'h5A, 8);
        rd(2'd1, d); chk("R6 resume full", d, 1);
        rd(2'd2, d); chk("R6 resume byte", d, 8'h5A);

        // R8 enable gating with receive-full set
        send_bits(8'h44, 8);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R8 write 0 clears", d, 0);
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R8 enable ignored", d, 0);
        send_bits(8'h77, 8);
        rd(2'd1, d); chk("R11 no overrun while off", d, 1);
        rd(2'd2, d); chk("R11 data kept while off", d, 8'h44);
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R8 enable after clear", d, 1);

        // R9 partial frame discarded
        send_bits(8'hE0, 3);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        send_bits(8'h12, 8);
        rd(2'd2, d); chk("R9 counter restarted", d, 8'h12);

        // R10 transmit-end flag
        @(negedge clk); tx_end_set = 1'b1;
        @(negedge clk); tx_end_set = 1'b0;
        rd(2'd1, d); chk("R10 tx_end set", d, 4);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R8 blocked by tx_end", d, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R10 tx_end cleared", d, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule